// File: doc/BRIEF.md
# Trace configuration register file with capability gating

This block holds the configuration state of a processor trace unit: a 64-bit control word, a status word that carries a packet byte counter, a context match register, and one pair of address bound registers for each address range. A static 32-bit capability word is applied at `cap_i`, and its low six bits state which optional features exist. Every write to the control word is checked field by field against those bits. A write that would set a field of a missing feature, or any access to a register that is not provided, is rejected. A rejected access raises a one-cycle fault pulse, and the target register keeps its previous contents.

The block also handles a warm reset. Depending on the capability word, that reset either keeps the configuration and stops tracing, or wipes everything. The block also decides whether turning trace on should request a sync packet. Packet generation and the address comparisons themselves belong to other blocks.

Register offsets on `addr_i` are: 0 control, 1 status, 2 context match, 3+2n range n lower bound, 4+2n range n upper bound. Any higher offset is unmapped. The range count `NUM_RANGES` is a 3-bit quantity (1 to 7).

Top module: `trc_cfg_regs`

## Requirements
- R1: A write to offset 0 that breaks no rule below stores the whole 64-bit word, and `ctl_o` shows it one cycle later. Bits not named in any rule (for example bit 2) can always be written.
- R2: If cap bit 0 is clear, then a control write with bit 7 (context filter enable) set faults, and any read or write of offset 2 (context match) faults.
- R3: If cap bit 1 is clear, then a control write faults when it sets bit 1 (cycle-accurate enable) or has a non-zero sync frequency in bits 27:24. A status write also faults when it carries a non-zero counter value in bits CNT_W-1:0.
- R4: The address configuration fields are 4 bits wide, with field n at bits 32+4n. A value above 2 always faults. A non-zero value in a field with n >= NUM_RANGES faults.
- R5: If cap bit 2 is clear, then any non-zero address configuration field faults, and any access to a range bound register (offsets 3 up to 2+2*NUM_RANGES) faults.
- R6: If cap bit 3 is clear, then a control write that sets bit 9 (timing packet enable) or puts a non-zero value in bits 17:14 (timing frequency) faults.
- R7: If cap bit 4 is clear, then a control write that sets bit 12 (software-write packets) or bit 5 (flow update on software write) faults.
- R8: If cap bit 5 is clear, then a control write that sets bit 4 (power event enable) faults.
- R9: A rejected access makes `fault_o` high for exactly the cycle after the access and changes no register. A faulting read returns 0 on `rdata_o`. An access to an unmapped offset always faults.
- R10: A warm reset with cap bit 2 set clears only control bit 0 and keeps all other registers. With cap bit 2 clear, a warm reset clears all registers. A warm reset overrides an access in the same cycle.
- R11: A control write that takes bit 0 from 0 to 1 pulses `sync_req_o` for one cycle, one cycle later. If cap bit 1 is set, the pulse is given only when the packet byte counter is zero. If cap bit 1 is clear, the pulse is given on every such enable.
- R12: With cap bit 1 set, the counter adds `byte_cnt_i` on every cycle in which control bit 0 is 1. With cap bit 1 clear, the counter stays zero.
- R13: Capability bits 31:6 have no effect on any decision.
- R14: A read that does not fault returns the addressed register on `rdata_o` one cycle after `rd_en_i`. The counter is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset request |
| cap_i | input | 32 | Static capability word |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| fault_o | output | 1 | One-cycle rejection pulse |
| byte_cnt_i | input | BYTE_W | Packet bytes emitted this cycle |
| ctl_o | output | 64 | Current control word |
| sync_req_o | output | 1 | Sync packet request pulse |

## Verification
Every result of an access appears exactly one clock edge after the access is presented: the fault pulse, the read data, the updated control word and the sync request. The bench drives each access on a falling edge, removes it on the next falling edge, and samples all outputs at that moment, so each result is seen in its only valid cycle. The counter total after k cycles of enabled tracing is known exactly, because the bench raises `byte_cnt_i` for a fixed count of falling-edge intervals. A warm reset is sampled one edge after its pulse. The bench sweeps all 64 values of the feature bits, with the reserved bits alternated, and derives every expected fault from the field rules.

// File: rtl/trc_cfg_pkg.sv
package trc_cfg_pkg;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned MAX_RANGES = 7;
  localparam int unsigned CFG_W      = 4;

  // control word bit positions
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned CYC_BIT   = 1;
  localparam int unsigned PWR_BIT   = 4;
  localparam int unsigned FUP_BIT   = 5;
  localparam int unsigned CTX_BIT   = 7;
  localparam int unsigned TPK_BIT   = 9;
  localparam int unsigned SWP_BIT   = 12;
  localparam int unsigned TFREQ_LSB = 14;
  localparam int unsigned SFREQ_LSB = 24;
  localparam int unsigned FREQ_W    = 4;
  localparam int unsigned CFG_LSB   = 32;

  // capability bit positions
  localparam int unsigned CAP_CTX   = 0;
  localparam int unsigned CAP_SYNC  = 1;
  localparam int unsigned CAP_RANGE = 2;
  localparam int unsigned CAP_TPK   = 3;
  localparam int unsigned CAP_SWP   = 4;
  localparam int unsigned CAP_PWR   = 5;

  // register offsets
  localparam int unsigned OFF_CTL = 0;
  localparam int unsigned OFF_STS = 1;
  localparam int unsigned OFF_CTX = 2;
  localparam int unsigned OFF_RNG = 3;
endpackage

// File: rtl/trc_access_check.sv
module trc_access_check
  import trc_cfg_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 2,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned CNT_W      = 32
) (
  input  logic [31:0]           cap_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  fault_o,
  output logic                  ctl_we_o,
  output logic                  sts_we_o,
  output logic                  ctx_we_o,
  output logic [NUM_RANGES-1:0] rng_a_we_o,
  output logic [NUM_RANGES-1:0] rng_b_we_o,
  output logic                  rd_ok_o
);
  localparam int unsigned NUM_REGS = OFF_RNG + 2 * NUM_RANGES;

  logic unused_bits;
  assign unused_bits = ^{cap_i[31:6], wdata_i};

  logic [MAX_RANGES-1:0] cfg_bad;
  for (genvar n = 0; n < MAX_RANGES; n++) begin : g_cfg
    logic [CFG_W-1:0] fld;
    assign fld = wdata_i[CFG_LSB + CFG_W*n +: CFG_W];
    assign cfg_bad[n] = (fld > CFG_W'(2)) ||
                        ((fld != '0) && ((n >= NUM_RANGES) || !cap_i[CAP_RANGE]));
  end

  logic ctl_bad, sts_bad;
  always_comb begin
    ctl_bad = |cfg_bad;
    if (!cap_i[CAP_CTX] && wdata_i[CTX_BIT]) ctl_bad = 1'b1;
    if (!cap_i[CAP_SYNC] && (wdata_i[CYC_BIT] || wdata_i[SFREQ_LSB +: FREQ_W] != '0))
      ctl_bad = 1'b1;
    if (!cap_i[CAP_TPK] && (wdata_i[TPK_BIT] || wdata_i[TFREQ_LSB +: FREQ_W] != '0))
      ctl_bad = 1'b1;
    if (!cap_i[CAP_SWP] && (wdata_i[SWP_BIT] || wdata_i[FUP_BIT])) ctl_bad = 1'b1;
    if (!cap_i[CAP_PWR] && wdata_i[PWR_BIT]) ctl_bad = 1'b1;
    sts_bad = !cap_i[CAP_SYNC] && (wdata_i[CNT_W-1:0] != '0);
  end

  logic is_ctl, is_sts, is_ctx, is_rng, is_none, acc;
  logic [ADDR_W-1:0] rel;
  assign acc     = wr_i | rd_i;
  assign is_ctl  = addr_i == ADDR_W'(OFF_CTL);
  assign is_sts  = addr_i == ADDR_W'(OFF_STS);
  assign is_ctx  = addr_i == ADDR_W'(OFF_CTX);
  assign is_rng  = (addr_i >= ADDR_W'(OFF_RNG)) && (addr_i < ADDR_W'(NUM_REGS));
  assign is_none = addr_i >= ADDR_W'(NUM_REGS);
  assign rel     = addr_i - ADDR_W'(OFF_RNG);

  assign fault_o = acc && (is_none ||
                           (is_ctx && !cap_i[CAP_CTX]) ||
                           (is_rng && !cap_i[CAP_RANGE]) ||
                           (wr_i && is_ctl && ctl_bad) ||
                           (wr_i && is_sts && sts_bad));

  assign ctl_we_o = wr_i && is_ctl && !fault_o;
  assign sts_we_o = wr_i && is_sts && !fault_o;
  assign ctx_we_o = wr_i && is_ctx && !fault_o;
  assign rd_ok_o  = rd_i && !fault_o;

  for (genvar n = 0; n < NUM_RANGES; n++) begin : g_rng_we
    logic hit;
    assign hit = wr_i && is_rng && !fault_o && (rel[ADDR_W-1:1] == (ADDR_W-1)'(n));
    assign rng_a_we_o[n] = hit && !rel[0];
    assign rng_b_we_o[n] = hit && rel[0];
  end
endmodule

// File: rtl/trc_ctl_reg.sv
module trc_ctl_reg
  import trc_cfg_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              keep_i,
  input  logic              sync_cfg_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cnt_zero_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic              sync_req_o
);
  logic [DATA_W-1:0] ctl_q;
  logic              sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      if (warm_i) begin
        ctl_q <= keep_i ? (ctl_q & ~(DATA_W'(1) << EN_BIT)) : '0;
      end else if (we_i) begin
        ctl_q  <= wdata_i;
        sync_q <= wdata_i[EN_BIT] && !ctl_q[EN_BIT] && (!sync_cfg_i || cnt_zero_i);
      end
    end
  end

  assign ctl_o      = ctl_q;
  assign sync_req_o = sync_q;

  p_sync_on_enable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> ctl_q[EN_BIT] && !$past(ctl_q[EN_BIT]));

  p_warm_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(warm_i) && $past(keep_i) |-> ctl_q[DATA_W-1:1] == $past(ctl_q[DATA_W-1:1]));

  for (genvar n = 0; n < MAX_RANGES; n++) begin : g_cfg_chk
    if (n < NUM_RANGES) begin : g_live
      p_cfg_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q[CFG_LSB + CFG_W*n +: CFG_W] <= CFG_W'(2));
    end else begin : g_absent
      p_cfg_absent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q[CFG_LSB + CFG_W*n +: CFG_W] == '0);
    end
  end
endmodule

// File: rtl/trc_pkt_cnt.sv
module trc_pkt_cnt #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              keep_i,
  input  logic              en_i,
  input  logic              tracing_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [BYTE_W-1:0] add_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (warm_i)            cnt_q <= keep_i ? cnt_q : '0;
    else if (we_i)              cnt_q <= wdata_i;
    else if (en_i && tracing_i) cnt_q <= cnt_q + CNT_W'(add_i);
  end

  assign cnt_o = cnt_q;

  p_cnt_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> cnt_q == '0);
endmodule

// File: rtl/trc_range_bank.sv
module trc_range_bank
  import trc_cfg_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               warm_i,
  input  logic                               keep_i,
  input  logic                               ctx_we_i,
  input  logic [NUM_RANGES-1:0]              a_we_i,
  input  logic [NUM_RANGES-1:0]              b_we_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W-1:0]                  ctx_o,
  output logic [NUM_RANGES-1:0][DATA_W-1:0]  a_o,
  output logic [NUM_RANGES-1:0][DATA_W-1:0]  b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctx_o <= '0;
    else if (warm_i)   ctx_o <= keep_i ? ctx_o : '0;
    else if (ctx_we_i) ctx_o <= wdata_i;
  end

  for (genvar n = 0; n < NUM_RANGES; n++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_o[n] <= '0;
        b_o[n] <= '0;
      end else if (warm_i) begin
        if (!keep_i) begin
          a_o[n] <= '0;
          b_o[n] <= '0;
        end
      end else begin
        if (a_we_i[n]) a_o[n] <= wdata_i;
        if (b_we_i[n]) b_o[n] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
  import trc_cfg_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 2,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned ADDR_W    = $clog2(OFF_RNG + 2 * NUM_RANGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [31:0]       cap_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fault_o,
  input  logic [BYTE_W-1:0] byte_cnt_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic              sync_req_o
);
  // warm reset overrides any access in the same cycle
  logic wr_v, rd_v;
  assign wr_v = wr_en_i & ~warm_rst_i;
  assign rd_v = rd_en_i & ~warm_rst_i;

  logic                  fault_d, ctl_we, sts_we, ctx_we, rd_ok;
  logic [NUM_RANGES-1:0] a_we, b_we;

  trc_access_check #(
    .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_check (
    .cap_i      (cap_i),
    .wr_i       (wr_v),
    .rd_i       (rd_v),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .fault_o    (fault_d),
    .ctl_we_o   (ctl_we),
    .sts_we_o   (sts_we),
    .ctx_we_o   (ctx_we),
    .rng_a_we_o (a_we),
    .rng_b_we_o (b_we),
    .rd_ok_o    (rd_ok)
  );

  logic [CNT_W-1:0] cnt;

  trc_ctl_reg #(.NUM_RANGES(NUM_RANGES)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_i     (warm_rst_i),
    .keep_i     (cap_i[CAP_RANGE]),
    .sync_cfg_i (cap_i[CAP_SYNC]),
    .we_i       (ctl_we),
    .wdata_i    (wdata_i),
    .cnt_zero_i (cnt == '0),
    .ctl_o      (ctl_o),
    .sync_req_o (sync_req_o)
  );

  trc_pkt_cnt #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warm_i    (warm_rst_i),
    .keep_i    (cap_i[CAP_RANGE]),
    .en_i      (cap_i[CAP_SYNC]),
    .tracing_i (ctl_o[EN_BIT]),
    .we_i      (sts_we),
    .wdata_i   (wdata_i[CNT_W-1:0]),
    .add_i     (byte_cnt_i),
    .cnt_o     (cnt)
  );

  logic [DATA_W-1:0]                 ctx;
  logic [NUM_RANGES-1:0][DATA_W-1:0] rng_a, rng_b;

  trc_range_bank #(.NUM_RANGES(NUM_RANGES)) u_rng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .warm_i   (warm_rst_i),
    .keep_i   (cap_i[CAP_RANGE]),
    .ctx_we_i (ctx_we),
    .a_we_i   (a_we),
    .b_we_i   (b_we),
    .wdata_i  (wdata_i),
    .ctx_o    (ctx),
    .a_o      (rng_a),
    .b_o      (rng_b)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFF_CTL)) rd_mux = ctl_o;
    if (addr_i == ADDR_W'(OFF_STS)) rd_mux = DATA_W'(cnt);
    if (addr_i == ADDR_W'(OFF_CTX)) rd_mux = ctx;
    for (int n = 0; n < NUM_RANGES; n++) begin
      if (addr_i == ADDR_W'(OFF_RNG + 2*n))     rd_mux = rng_a[n];
      if (addr_i == ADDR_W'(OFF_RNG + 2*n + 1)) rd_mux = rng_b[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      fault_o <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? rd_mux : '0;
      fault_o <= fault_d;
    end
  end

  p_fault_no_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(ctl_o));

  p_fault_needs_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(wr_en_i || rd_en_i) && !$past(warm_rst_i));

  p_fault_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rdata_o == '0);

  p_warm_stops_trace_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(warm_rst_i) |-> !ctl_o[EN_BIT]);
endmodule

// File: tb/trc_cfg_regs_tb.sv
`timescale 1ns/1ps
module trc_cfg_regs_tb_top;
  localparam int unsigned NR = 2;
  localparam int unsigned AW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm = 1'b0;
  logic [31:0] cap = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        fault;
  logic [7:0]  byte_cnt = '0;
  logic [63:0] ctl;
  logic        sync_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trc_cfg_regs #(.NUM_RANGES(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .cap_i(cap),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fault_o(fault), .byte_cnt_i(byte_cnt),
    .ctl_o(ctl), .sync_req_o(sync_req)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cold(logic [31:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    cap = c;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [63:0] vec(int i);
    case (i)
      0:  return 64'd1 << 7;
      1:  return 64'd1 << 1;
      2:  return 64'h3 << 24;
      3:  return 64'd1 << 9;
      4:  return 64'h5 << 14;
      5:  return 64'd1 << 12;
      6:  return 64'd1 << 5;
      7:  return 64'd1 << 4;
      8:  return 64'h1 << 32;
      9:  return 64'h2 << 36;
      10: return 64'h3 << 32;
      11: return 64'h1 << (32 + 4*NR);
      12: return 64'd1 << 2;
      default: return (64'd1 << 2) | (64'd1 << 4) | (64'h2 << 32);
    endcase
  endfunction

  function automatic string tag(int i);
    case (i)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R6";
      5, 6: return "R7";
      7, 13: return "R8";
      8, 9: return "R5";
      10, 11: return "R4";
      default: return "R1";
    endcase
  endfunction

  function automatic bit exp_fault(logic [5:0] c, logic [63:0] w);
    bit f = 1'b0;
    if (!c[0] && w[7]) f = 1'b1;
    if (!c[1] && (w[1] || w[27:24] != 0)) f = 1'b1;
    if (!c[3] && (w[9] || w[17:14] != 0)) f = 1'b1;
    if (!c[4] && (w[12] || w[5])) f = 1'b1;
    if (!c[5] && w[4]) f = 1'b1;
    for (int n = 0; n < 7; n++) begin
      logic [3:0] fld = w[32 + 4*n +: 4];
      if (fld > 2 || (fld != 0 && (n >= NR || !c[2]))) f = 1'b1;
    end
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int ci = 0; ci < 64; ci++) begin
      logic [5:0] c = 6'(ci);
      logic [63:0] base = 64'd4;
      // R13: reserved bits alternate between all-ones and zero
      cold({{26{c[0] ^ c[3]}}, c});
      chk("R1 reset ctl", ctl, 0);
      chk("R9 reset fault", {63'd0, fault}, 0);
      chk("R11 reset sync", {63'd0, sync_req}, 0);

      for (int v = 0; v < 14; v++) begin
        bit f;
        wr(0, base);
        chk("R1 preload", {63'd0, fault}, 0);
        wr(0, vec(v));
        f = exp_fault(c, vec(v));
        chk({tag(v), " fault"}, {63'd0, fault}, {63'd0, f});
        chk({tag(v), " R9 ctl"}, ctl, f ? base : vec(v));
      end
      wr(0, 0);

      wr(1, 64'd5);
      chk("R3 status fault", {63'd0, fault}, {63'd0, !c[1]});
      rd(1);
      chk("R14 status read", rdata, c[1] ? 64'd5 : 64'd0);
      wr(1, 0);

      wr(2, 64'hDEAD_0000_1234);
      chk("R2 ctx write fault", {63'd0, fault}, {63'd0, !c[0]});
      rd(2);
      chk("R2 ctx read fault", {63'd0, fault}, {63'd0, !c[0]});
      chk("R14 ctx read", rdata, c[0] ? 64'hDEAD_0000_1234 : 64'd0);

      wr(3, 64'hA0);
      chk("R5 range A fault", {63'd0, fault}, {63'd0, !c[2]});
      wr(6, 64'hB1);
      chk("R5 range B fault", {63'd0, fault}, {63'd0, !c[2]});
      rd(6);
      chk("R14 range read", rdata, c[2] ? 64'hB1 : 64'd0);
      rd(3);
      chk("R14 range A read", rdata, c[2] ? 64'hA0 : 64'd0);

      rd(7);
      chk("R9 unmapped fault", {63'd0, fault}, 1);
      chk("R9 unmapped data", rdata, 0);

      wr(1, 0);
      wr(0, 64'd1);
      chk("R11 sync first", {63'd0, sync_req}, 1);
      chk("R1 enable", ctl, 1);
      @(negedge clk);
      chk("R11 sync pulse", {63'd0, sync_req}, 0);
      byte_cnt = 8'd3;
      repeat (5) @(negedge clk);
      byte_cnt = 8'd0;
      wr(0, 0);
      rd(1);
      chk("R12 count", rdata, c[1] ? 64'd15 : 64'd0);
      wr(0, 64'd1);
      chk("R11 sync nonzero cnt", {63'd0, sync_req}, {63'd0, !c[1]});
      wr(0, 0);

      wr(0, 64'd5);
      @(negedge clk);
      warm = 1'b1;
      @(negedge clk);
      warm = 1'b0;
      chk("R10 warm ctl", ctl, c[2] ? 64'd4 : 64'd0);
      rd(1);
      chk("R10 warm cnt", rdata, (c[2] && c[1]) ? 64'd15 : 64'd0);
      rd(6);
      chk("R10 warm range", rdata, c[2] ? 64'hB1 : 64'd0);

      // R10: warm reset beats a same-cycle write
      @(negedge clk);
      addr = 0; wdata = 64'd4 | 64'd1; wr_en = 1'b1; warm = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; warm = 1'b0;
      chk("R10 warm over write", ctl, c[2] ? 64'd4 : 64'd0);
      chk("R10 warm no fault", {63'd0, fault}, 0);
    end

    cold(32'hFFFF_FFC0);
    wr(0, 64'd1 << 4);
    chk("R13 reserved set, feature absent", {63'd0, fault}, 1);
    cold(32'h0000_003F);
    wr(0, 64'd1 << 4);
    chk("R13 reserved clear, feature present", {63'd0, fault}, 0);
    chk("R8 power bit stored", ctl, 64'd1 << 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule